// File: doc/BRIEF.md
# Bitslice Permutation Unit

This block performs the bit shuffles that a bitsliced cryptographic datapath needs around its Boolean operations. It takes two data words and an operation select and returns two data words. One operation interleaves the bits of the two operands, so repeated use turns row-ordered data into bitsliced columns. A second operation undoes that interleave exactly. A third operation rotates masking shares inside their groups. The groups are two or four adjacent bits, and an immediate picks the group size. Because a rotation never moves a bit out of its group, all shares of one logical bit stay together in the word. A masked multiplication can then form every partial share product with one AND per rotation step.

The permutation logic is purely combinational. A thin register stage around it captures one request on each cycle where `valid_in` is high. It presents the results on the next cycle with `valid_out`. That stage is a two-state machine. `ST_EMPTY` means no fresh result and `ST_FULL` means a result was loaded on the last edge. The state moves to `ST_FULL` on any cycle with `valid_in` high and to `ST_EMPTY` on any cycle without it. Reset forces `ST_EMPTY`.

Top module: `bsperm_unit`

## Requirements
- R1: While `rst_n` is low, on the next clock edge `valid_out`, `res_lo` and `res_hi` become 0.
- R2: A request taken with `valid_in` high appears on `res_lo`/`res_hi` one clock later with `valid_out` high. In a cycle after `valid_in` was low, `valid_out` is low and both results keep their previous values.
- R3: With `op` = 0 (interleave), `res_lo[2i]` = `src_a[i]` and `res_lo[2i+1]` = `src_b[i]` for i in 0..15. `res_hi[2i]` = `src_a[16+i]` and `res_hi[2i+1]` = `src_b[16+i]`.
- R4: With `op` = 1 (de-interleave), the operands are taken as a low word (`src_a`) and a high word (`src_b`) in the R3 layout. `res_lo` returns the even bits and `res_hi` returns the odd bits: `res_lo[i]` = `src_a[2i]`, `res_lo[16+i]` = `src_b[2i]`, `res_hi[i]` = `src_a[2i+1]`, `res_hi[16+i]` = `src_b[2i+1]`. Feeding an R3 result back through this operation returns the original operands.
- R5: With `op` = 2 and `imm` = 0 (two-share rotate), bits 2k and 2k+1 of each operand swap for k in 0..15. `res_lo` comes from `src_a` and `res_hi` from `src_b`.
- R6: With `op` = 2 and `imm` = 1 (four-share rotate), each nibble n = bits [4k+3:4k] of each operand becomes {n[2:0], n[3]}. `res_lo` comes from `src_a` and `res_hi` from `src_b`.
- R7: With `op` = 2 and `imm` = 2 or 3, `res_lo` = `src_a` and `res_hi` = `src_b`.
- R8: With `op` = 3 (reserved), `res_lo` = `src_a` and `res_hi` = `src_b` for any `imm`.
- R9: Every operation is a bit permutation. The total number of ones in `res_lo` and `res_hi` equals that of the captured operands. A two-share rotate applied twice, or a four-share rotate applied four times, returns the operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_in | input | 1 | Capture a request this cycle |
| op | input | 2 | Operation: 0 interleave, 1 de-interleave, 2 share rotate, 3 reserved |
| imm | input | 2 | Share group size for rotate: 0 two-share, 1 four-share |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second operand |
| valid_out | output | 1 | Results were loaded on the last edge |
| res_lo | output | 32 | First result word |
| res_hi | output | 32 | Second result word |

## Verification
The interleave is driven with one-hot and alternating operands, which show whether each source bit lands on the right parity and half. All-ones against all-zero operands show which operand feeds even positions and which feeds odd ones. Round trips through the interleave and then the de-interleave, using arbitrary words, separate a correct inverse from one that only preserves the number of ones. The rotates are compared against a reference model over random words, and single-bit patterns at group edges expose any shift that leaks across a group boundary. Undefined immediates and the reserved opcode are driven with distinctive words so that any alteration shows at the outputs.

// File: rtl/bsperm_pkg.sv
package bsperm_pkg;

    localparam int OP_W  = 2;
    localparam int IMM_W = 2;

    typedef enum logic [OP_W-1:0] {
        OP_ILV  = 2'd0,
        OP_DILV = 2'd1,
        OP_SROT = 2'd2,
        OP_RSVD = 2'd3
    } bsp_op_e;

    typedef enum logic [IMM_W-1:0] {
        IMM_TWO  = 2'd0,
        IMM_FOUR = 2'd1,
        IMM_UND2 = 2'd2,
        IMM_UND3 = 2'd3
    } bsp_imm_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } bsp_state_e;

endpackage

// File: rtl/bsperm_interleave.sv
module bsperm_interleave #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    output logic [DATA_W-1:0] out_lo,
    output logic [DATA_W-1:0] out_hi
);
    localparam int HALF = DATA_W / 2;

    for (genvar i = 0; i < HALF; i++) begin : g_bit
        assign out_lo[2*i]   = in_a[i];
        assign out_lo[2*i+1] = in_b[i];
        assign out_hi[2*i]   = in_a[HALF+i];
        assign out_hi[2*i+1] = in_b[HALF+i];
    end
endmodule

// File: rtl/bsperm_deinterleave.sv
module bsperm_deinterleave #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] in_lo,
    input  logic [DATA_W-1:0] in_hi,
    output logic [DATA_W-1:0] out_a,
    output logic [DATA_W-1:0] out_b
);
    localparam int HALF = DATA_W / 2;

    for (genvar i = 0; i < HALF; i++) begin : g_bit
        assign out_a[i]      = in_lo[2*i];
        assign out_a[HALF+i] = in_hi[2*i];
        assign out_b[i]      = in_lo[2*i+1];
        assign out_b[HALF+i] = in_hi[2*i+1];
    end
endmodule

// File: rtl/bsperm_subrot.sv
module bsperm_subrot
    import bsperm_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] in_w,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] out_w
);
    localparam int PAIRS = DATA_W / 2;
    localparam int NIBS  = DATA_W / 4;

    logic [DATA_W-1:0] rot_two;
    logic [DATA_W-1:0] rot_four;

    for (genvar k = 0; k < PAIRS; k++) begin : g_pair
        assign rot_two[2*k]   = in_w[2*k+1];
        assign rot_two[2*k+1] = in_w[2*k];
    end

    for (genvar k = 0; k < NIBS; k++) begin : g_nib
        assign rot_four[4*k+3:4*k] = {in_w[4*k+2:4*k], in_w[4*k+3]};
    end

    always_comb begin
        unique case (bsp_imm_e'(imm))
            IMM_TWO:  out_w = rot_two;
            IMM_FOUR: out_w = rot_four;
            default:  out_w = in_w;
        endcase
    end
endmodule

// File: rtl/bsperm_core.sv
module bsperm_core
    import bsperm_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [OP_W-1:0]   op,
    input  logic [IMM_W-1:0]  imm,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic [DATA_W-1:0] y_lo,
    output logic [DATA_W-1:0] y_hi
);
    logic [DATA_W-1:0] ilv_lo, ilv_hi;
    logic [DATA_W-1:0] dil_a, dil_b;
    logic [DATA_W-1:0] rot_a, rot_b;

    bsperm_interleave #(.DATA_W(DATA_W)) u_ilv (
        .in_a   (src_a),
        .in_b   (src_b),
        .out_lo (ilv_lo),
        .out_hi (ilv_hi)
    );

    bsperm_deinterleave #(.DATA_W(DATA_W)) u_dil (
        .in_lo (src_a),
        .in_hi (src_b),
        .out_a (dil_a),
        .out_b (dil_b)
    );

    bsperm_subrot #(.DATA_W(DATA_W)) u_rot_a (
        .in_w  (src_a),
        .imm   (imm),
        .out_w (rot_a)
    );

    bsperm_subrot #(.DATA_W(DATA_W)) u_rot_b (
        .in_w  (src_b),
        .imm   (imm),
        .out_w (rot_b)
    );

    always_comb begin
        unique case (bsp_op_e'(op))
            OP_ILV:  begin y_lo = ilv_lo; y_hi = ilv_hi; end
            OP_DILV: begin y_lo = dil_a;  y_hi = dil_b;  end
            OP_SROT: begin y_lo = rot_a;  y_hi = rot_b;  end
            default: begin y_lo = src_a;  y_hi = src_b;  end
        endcase
    end
endmodule

// File: rtl/bsperm_unit.sv
module bsperm_unit
    import bsperm_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_in,
    input  logic [1:0]        op,
    input  logic [1:0]        imm,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic              valid_out,
    output logic [DATA_W-1:0] res_lo,
    output logic [DATA_W-1:0] res_hi
);
    bsp_state_e        state_q, state_d;
    logic [DATA_W-1:0] core_lo, core_hi;

    bsperm_core #(.DATA_W(DATA_W)) u_core (
        .op    (op),
        .imm   (imm),
        .src_a (src_a),
        .src_b (src_b),
        .y_lo  (core_lo),
        .y_hi  (core_hi)
    );

    always_comb begin
        unique case (state_q)
            ST_EMPTY: state_d = valid_in ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_d = valid_in ? ST_FULL : ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_lo <= '0;
            res_hi <= '0;
        end else if (valid_in) begin
            res_lo <= core_lo;
            res_hi <= core_hi;
        end
    end

    assign valid_out = (state_q == ST_FULL);
endmodule

// File: rtl/bsperm_unit_chk.sv
module bsperm_unit_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              valid_in,
    input logic [1:0]        op,
    input logic [1:0]        imm,
    input logic [DATA_W-1:0] src_a,
    input logic [DATA_W-1:0] src_b,
    input logic              valid_out,
    input logic [DATA_W-1:0] res_lo,
    input logic [DATA_W-1:0] res_hi
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!valid_out && res_lo == '0 && res_hi == '0))
        else $error("reset did not clear outputs"); // R1

    AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> valid_out)
        else $error("valid_out missing after request"); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> (!valid_out && $stable(res_lo) && $stable(res_hi)))
        else $error("outputs moved without request"); // R2

    AST_ONES_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> ($countones(res_lo) + $countones(res_hi) ==
                      $countones($past(src_a)) + $countones($past(src_b))))
        else $error("ones count changed"); // R9

    AST_UNDEF_IMM: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && op == 2'd2 && imm[1]) |=>
        (res_lo == $past(src_a) && res_hi == $past(src_b)))
        else $error("undefined immediate altered data"); // R7

    AST_RSVD_OP: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && op == 2'd3) |=>
        (res_lo == $past(src_a) && res_hi == $past(src_b)))
        else $error("reserved opcode altered data"); // R8
endmodule

bind bsperm_unit bsperm_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_in  (valid_in),
    .op        (op),
    .imm       (imm),
    .src_a     (src_a),
    .src_b     (src_b),
    .valid_out (valid_out),
    .res_lo    (res_lo),
    .res_hi    (res_hi)
);

// File: tb/bsperm_unit_tb.sv
module bsperm_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_in = 1'b0;
    logic [1:0]  op = '0;
    logic [1:0]  imm = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic        valid_out;
    logic [31:0] res_lo, res_hi;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    bsperm_unit u_dut (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .op(op), .imm(imm),
        .src_a(src_a), .src_b(src_b), .valid_out(valid_out),
        .res_lo(res_lo), .res_hi(res_hi)
    );

    // op(2) imm(2) a(32) b(32)
    localparam logic [67:0] VEC [12] = '{
        {2'd0, 2'd0, 32'h0000_0001, 32'h0000_0000},
        {2'd0, 2'd3, 32'hFFFF_FFFF, 32'h0000_0000},
        {2'd0, 2'd1, 32'h8000_0000, 32'h0001_0000},
        {2'd1, 2'd0, 32'h5555_5555, 32'hAAAA_AAAA},
        {2'd1, 2'd2, 32'h0000_0002, 32'h4000_0000},
        {2'd2, 2'd0, 32'h0000_0001, 32'h8000_0000},
        {2'd2, 2'd0, 32'h1234_5678, 32'h9ABC_DEF0},
        {2'd2, 2'd1, 32'h0000_0008, 32'h1111_1111},
        {2'd2, 2'd1, 32'hDEAD_BEEF, 32'h0F0F_0F0F},
        {2'd2, 2'd2, 32'hCAFE_F00D, 32'h0BAD_C0DE},
        {2'd2, 2'd3, 32'h0123_4567, 32'h89AB_CDEF},
        {2'd3, 2'd1, 32'hA5A5_5A5A, 32'h3C3C_C3C3}
    };

    function automatic string req_of(input logic [1:0] o, input logic [1:0] im);
        if (o == 2'd0) return "R3";
        if (o == 2'd1) return "R4";
        if (o == 2'd3) return "R8";
        if (im == 2'd0) return "R5";
        if (im == 2'd1) return "R6";
        return "R7";
    endfunction

    function automatic logic [31:0] rot2(input logic [31:0] x);
        logic [31:0] r;
        for (int k = 0; k < 16; k++) begin
            r[2*k] = x[2*k+1];
            r[2*k+1] = x[2*k];
        end
        return r;
    endfunction

    function automatic logic [31:0] rot4(input logic [31:0] x);
        logic [31:0] r;
        for (int k = 0; k < 8; k++)
            for (int j = 0; j < 4; j++)
                r[4*k+j] = x[4*k+((j+3)%4)];
        return r;
    endfunction

    function automatic logic [63:0] model(input logic [1:0] o, input logic [1:0] im,
                                          input logic [31:0] a, input logic [31:0] b);
        logic [31:0] lo, hi;
        lo = a; hi = b;
        if (o == 2'd0) begin
            for (int i = 0; i < 16; i++) begin
                lo[2*i] = a[i];    lo[2*i+1] = b[i];
                hi[2*i] = a[16+i]; hi[2*i+1] = b[16+i];
            end
        end else if (o == 2'd1) begin
            for (int i = 0; i < 16; i++) begin
                lo[i] = a[2*i];   lo[16+i] = b[2*i];
                hi[i] = a[2*i+1]; hi[16+i] = b[2*i+1];
            end
        end else if (o == 2'd2 && im == 2'd0) begin
            lo = rot2(a); hi = rot2(b);
        end else if (o == 2'd2 && im == 2'd1) begin
            lo = rot4(a); hi = rot4(b);
        end
        return {hi, lo};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [1:0] o, input logic [1:0] im,
                         input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        op = o; imm = im; src_a = a; src_b = b; valid_in = 1'b1;
        @(negedge clk);
        valid_in = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [63:0] e;
        logic [31:0] sa, sb, t;
        repeat (3) @(negedge clk);
        // R1: outputs cleared by reset
        chk("R1", "valid_out", {31'd0, valid_out}, 32'd0);
        chk("R1", "res_lo", res_lo, 32'd0);
        chk("R1", "res_hi", res_hi, 32'd0);
        rst_n = 1'b1;

        // Table walk
        for (int v = 0; v < 12; v++) begin
            apply(VEC[v][67:66], VEC[v][65:64], VEC[v][63:32], VEC[v][31:0]);
            e = model(VEC[v][67:66], VEC[v][65:64], VEC[v][63:32], VEC[v][31:0]);
            chk("R2", "valid_out", {31'd0, valid_out}, 32'd1);
            chk(req_of(VEC[v][67:66], VEC[v][65:64]), "res_lo", res_lo, e[31:0]);
            chk(req_of(VEC[v][67:66], VEC[v][65:64]), "res_hi", res_hi, e[63:32]);
        end

        // R2: hold while idle, with changing inputs
        sa = res_lo; sb = res_hi;
        src_a = 32'hFFFF_0000; src_b = 32'h1357_9BDF; op = 2'd0;
        @(negedge clk);
        @(negedge clk);
        chk("R2", "idle valid_out", {31'd0, valid_out}, 32'd0);
        chk("R2", "idle res_lo", res_lo, sa);
        chk("R2", "idle res_hi", res_hi, sb);

        // R4: round trip interleave -> de-interleave
        for (int n = 0; n < 8; n++) begin
            sa = $urandom; sb = $urandom;
            apply(2'd0, 2'd0, sa, sb);
            apply(2'd1, 2'd0, res_lo, res_hi);
            chk("R4", "roundtrip a", res_lo, sa);
            chk("R4", "roundtrip b", res_hi, sb);
        end

        // R5 / R6: random rotates against model
        for (int n = 0; n < 20; n++) begin
            sa = $urandom; sb = $urandom;
            apply(2'd2, 2'd0, sa, sb);
            chk("R5", "rand lo", res_lo, rot2(sa));
            chk("R5", "rand hi", res_hi, rot2(sb));
            apply(2'd2, 2'd1, sa, sb);
            chk("R6", "rand lo", res_lo, rot4(sa));
            chk("R6", "rand hi", res_hi, rot4(sb));
        end

        // R9: repeated rotates return the operand
        sa = 32'h9E37_79B9;
        apply(2'd2, 2'd0, sa, 32'd0);
        apply(2'd2, 2'd0, res_lo, 32'd0);
        chk("R9", "two-share x2", res_lo, sa);
        t = sa;
        for (int n = 0; n < 4; n++) begin
            apply(2'd2, 2'd1, t, 32'd0);
            t = res_lo;
        end
        chk("R9", "four-share x4", t, sa);

        // R1: reset after a loaded result
        apply(2'd3, 2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "mid reset valid_out", {31'd0, valid_out}, 32'd0);
        chk("R1", "mid reset res_lo", res_lo, 32'd0);
        chk("R1", "mid reset res_hi", res_hi, 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule